// File: doc/BRIEF.md
# Periodic Lamp Update Timer

This block is a bus-slave peripheral that drives a bank of indicator lamps. Software writes lamp patterns into a set of 16-bit shadow registers; those writes do not reach the lamp pins right away. A millisecond-granular interval timer counts pulses of an external 1 ms tick. Each time the programmed period has elapsed, the timer copies the whole shadow bank onto the live lamp outputs at once, sets an event flag and, if enabled, raises an interrupt request.

The timer, the event flag and the interrupt keep working when no panel is attached. Software can therefore use the block as a general-purpose interval timer with a period of 1 to 1000 ms. A 2-bit test-mode field can force every lamp on or off without disturbing the live pattern. Lamp fields wider than 16 bits span consecutive shadow registers, with the least significant word at the lowest address.

The register port is word addressed. Word 1 is the control/status word, word 3 is the period word, and words 4 and up hold the shadow lamp registers. Every register is 16 bits wide and all of them read back.

Top module: `lamp_update_timer`

## Requirements
- R1: After reset, the control/status word reads 0 apart from bit 15, the period word reads 10, all lamp outputs are 0 and `irq` is low.
- R2: Bit 15 of the control/status word (word 1) reads 1 exactly when `panel_ok` is low. Writes to bit 15 have no effect.
- R3: With period P in bits 9:0 of the period word (word 3), where 1 ≤ P ≤ 1000, an update occurs on every P-th `tick_1ms` pulse. Counting restarts from zero whenever the period word is written.
- R4: A period of 0 stops updates: ticks then set no event and leave the lamps unchanged.
- R5: A period write above 1000 is stored as 1000. Bits 15:10 of the written data are ignored, and the period word reads back with bits 15:10 at 0.
- R6: A write to a shadow register reads back at once but reaches the lamp outputs only at the next update.
- R7: Bit 7 of the control/status word (the event flag) is set by each update and cleared by a read of that word. If an update and a status read fall in the same cycle, the read returns the old value and the flag ends up set.
- R8: `irq` is high exactly while both the event flag and the interrupt-enable bit 6 of the control/status word are set. Setting bit 6 while the event is pending raises `irq` with no new tick.
- R9: Control/status bits 1:0 select the lamp mode. Mode 0 shows the live pattern, modes 1 and 2 drive every lamp to 1, and mode 3 drives every lamp to 0. Returning to mode 0 shows the retained live pattern.
- R10: With `panel_ok` low, the timer, the event flag, `irq` and the lamp copy behave the same as with a panel connected.
- R11: The shadow register at word 4+k drives `lamps[16k+15:16k]`, so the low word of a wide lamp field sits at the lower address.
- R12: Writing bit 7 of the control/status word neither sets nor clears the event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | WORD_W | Word address of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a status read clears the event flag |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_word` (combinational) |
| panel_ok | input | 1 | High while a lamp panel is connected |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| lamps | output | LAMP_REGS*16 | Lamp outputs after the test-mode override |
| irq | output | 1 | Update interrupt request (level) |

## Verification
The assertions check on every cycle that an update happens only on a tick and never with a zero period. They also check that the millisecond count stays below the period and that the stored period never exceeds 1000. On the event flag, they check that an update sets it and that a status read with no coinciding update clears it. Lamps are checked to hold still unless an update or a mode change occurred. The bench scenarios show the behaviour the assertions cannot: the exact tick count between updates across a sweep of periods, the values stored by the period clamp, and the lamp patterns under each test mode. The same scenarios also cover the delayed visibility of shadow writes, the word ordering of wide lamp fields, and operation without a panel.

// File: rtl/lampupd_pkg.sv
package lampupd_pkg;

    typedef enum logic [1:0] {
        LMODE_LIVE   = 2'd0,
        LMODE_LIGHT  = 2'd1,
        LMODE_FULL   = 2'd2,
        LMODE_DARK   = 2'd3
    } lmode_e;

    localparam int PER_W = 10;

    typedef struct packed {
        logic             evt;
        logic             ie;
        lmode_e           mode;
        logic [PER_W-1:0] period;
    } ctl_t;

endpackage

// File: rtl/lampupd_timer_core.sv
module lampupd_timer_core #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    output logic             upd,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             upd_d;

    always_comb begin
        cnt_d = cnt_q;
        upd_d = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (tick && (period != '0)) begin
            if (cnt_q >= period - CNT_W'(1)) begin
                upd_d = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign upd = upd_d;
    assign cnt = cnt_q;
endmodule

// File: rtl/lampupd_shadow_bank.sv
module lampupd_shadow_bank #(
    parameter int NREG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG-1:0]    we,
    input  logic [15:0]        wdata,
    input  logic               upd,
    output logic [NREG*16-1:0] shadow,
    output logic [NREG*16-1:0] live
);
    logic [NREG-1:0][15:0] sh_d, sh_q, lv_d, lv_q;

    always_comb begin
        sh_d = sh_q;
        lv_d = lv_q;
        for (int k = 0; k < NREG; k++) begin
            if (we[k]) sh_d[k] = wdata;
        end
        // the copy takes the shadow contents as they stood before this edge
        if (upd) lv_d = sh_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            lv_q <= '0;
        end else begin
            sh_q <= sh_d;
            lv_q <= lv_d;
        end
    end

    assign shadow = sh_q;
    assign live   = lv_q;
endmodule

// File: rtl/lampupd_override.sv
module lampupd_override
    import lampupd_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  lmode_e           mode,
    input  logic [WIDTH-1:0] live,
    output logic [WIDTH-1:0] lamps
);
    always_comb begin
        unique case (mode)
            LMODE_LIGHT, LMODE_FULL: lamps = '1;
            LMODE_DARK:              lamps = '0;
            default:                 lamps = live;
        endcase
    end
endmodule

// File: rtl/lamp_update_timer.sv
module lamp_update_timer
    import lampupd_pkg::*;
#(
    parameter int LAMP_REGS    = 4,
    parameter int WORD_W       = 5,
    parameter int RESET_PERIOD = 10,
    parameter int MAX_PERIOD   = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WORD_W-1:0]      bus_word,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [15:0]            bus_wdata,
    output logic [15:0]            bus_rdata,
    input  logic                   panel_ok,
    input  logic                   tick_1ms,
    output logic [LAMP_REGS*16-1:0] lamps,
    output logic                   irq
);
    localparam int LAMP_W      = LAMP_REGS * 16;
    localparam int STATUS_WORD = 1;
    localparam int PERIOD_WORD = 3;
    localparam int SHADOW_BASE = 4;
    localparam logic [PER_W-1:0] PER_MAX = PER_W'(MAX_PERIOD);
    localparam logic [PER_W-1:0] PER_RST = PER_W'(RESET_PERIOD);

    ctl_t ctl_d, ctl_q;

    logic                 wr_status, wr_period, rd_status;
    logic                 upd;
    logic [PER_W-1:0]     cnt_now;
    logic [LAMP_REGS-1:0] sh_we;
    logic [LAMP_W-1:0]    shadow, live;

    assign wr_status = bus_wr && (bus_word == WORD_W'(STATUS_WORD));
    assign wr_period = bus_wr && (bus_word == WORD_W'(PERIOD_WORD));
    assign rd_status = bus_rd && (bus_word == WORD_W'(STATUS_WORD));

    generate
        for (genvar k = 0; k < LAMP_REGS; k++) begin : g_we
            assign sh_we[k] = bus_wr && (bus_word == WORD_W'(SHADOW_BASE + k));
        end
    endgenerate

    always_comb begin
        ctl_d = ctl_q;
        if (wr_status) begin
            ctl_d.ie   = bus_wdata[6];
            ctl_d.mode = lmode_e'(bus_wdata[1:0]);
        end
        if (wr_period) begin
            ctl_d.period = (bus_wdata[PER_W-1:0] > PER_MAX) ? PER_MAX : bus_wdata[PER_W-1:0];
        end
        if (rd_status) ctl_d.evt = 1'b0;
        if (upd)       ctl_d.evt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.evt    <= 1'b0;
            ctl_q.ie     <= 1'b0;
            ctl_q.mode   <= LMODE_LIVE;
            ctl_q.period <= PER_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lampupd_timer_core #(.CNT_W(PER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1ms),
        .restart (wr_period),
        .period  (ctl_q.period),
        .upd     (upd),
        .cnt     (cnt_now)
    );

    lampupd_shadow_bank #(.NREG(LAMP_REGS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sh_we),
        .wdata  (bus_wdata),
        .upd    (upd),
        .shadow (shadow),
        .live   (live)
    );

    lampupd_override #(.WIDTH(LAMP_W)) u_ovr (
        .mode  (ctl_q.mode),
        .live  (live),
        .lamps (lamps)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_word == WORD_W'(STATUS_WORD)) begin
            bus_rdata[15]  = ~panel_ok;
            bus_rdata[7]   = ctl_q.evt;
            bus_rdata[6]   = ctl_q.ie;
            bus_rdata[1:0] = ctl_q.mode;
        end else if (bus_word == WORD_W'(PERIOD_WORD)) begin
            bus_rdata[PER_W-1:0] = ctl_q.period;
        end
        for (int k = 0; k < LAMP_REGS; k++) begin
            if (bus_word == WORD_W'(SHADOW_BASE + k)) bus_rdata = shadow[k*16 +: 16];
        end
    end

    assign irq = ctl_q.evt & ctl_q.ie;

    logic [PER_W-1:0] per_now;
    logic             evt_now;
    logic [1:0]       mode_now;
    assign per_now  = ctl_q.period;
    assign evt_now  = ctl_q.evt;
    assign mode_now = ctl_q.mode;
endmodule

// File: rtl/lamp_update_timer_chk.sv
module lamp_update_timer_chk #(
    parameter int LW      = 64,
    parameter int PW      = 10,
    parameter int MAX_PER = 1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_1ms,
    input logic          upd,
    input logic [PW-1:0] per_now,
    input logic [PW-1:0] cnt_now,
    input logic          evt_now,
    input logic          rd_status,
    input logic [1:0]    mode_now,
    input logic [LW-1:0] lamps
);
    // R3: an update happens only on a millisecond tick
    a_r3_upd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> tick_1ms);

    // R3: the running count stays below a nonzero period
    a_r3_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        (per_now != '0) |-> (cnt_now < per_now));

    // R4: zero period never updates
    a_r4_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (per_now == '0) |-> !upd);

    // R5: stored period bounded
    a_r5_period_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        per_now <= PW'(MAX_PER));

    // R7: an update leaves the event flag set
    a_r7_update_sets: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> evt_now);

    // R7: a status read with no coinciding update clears the flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !upd) |=> !evt_now);

    // R6: lamps move only on an update or a mode change
    a_r6_lamps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> (!$stable(mode_now) || $stable(lamps)));
endmodule

bind lamp_update_timer lamp_update_timer_chk #(
    .LW      (LAMP_REGS*16),
    .PW      (lampupd_pkg::PER_W),
    .MAX_PER (MAX_PERIOD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1ms  (tick_1ms),
    .upd       (upd),
    .per_now   (per_now),
    .cnt_now   (cnt_now),
    .evt_now   (evt_now),
    .rd_status (rd_status),
    .mode_now  (mode_now),
    .lamps     (lamps)
);

// File: tb/tb_lamp_update_timer.sv
module tb_lamp_update_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 2;
    localparam int WW = 5;
    localparam int LW = NREG * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] bus_word = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic          panel_ok = 1'b1;
    logic          tick_1ms = 1'b0;
    logic [LW-1:0] lamps;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lamp_update_timer #(.LAMP_REGS(NREG), .WORD_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .panel_ok(panel_ok), .tick_1ms(tick_1ms), .lamps(lamps), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int w, input logic [15:0] d);
        @(negedge clk);
        bus_word = WW'(w); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int w, output logic [15:0] d);
        @(negedge clk);
        bus_word = WW'(w); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1ms = 1'b1;
        @(negedge clk);
        tick_1ms = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 lamps", lamps, 0);
        check("R1 irq", {31'd0, irq}, 0);
        rd(1, v); check("R1 status", {16'd0, v}, 0);
        rd(3, v); check("R1 period", {16'd0, v}, 10);

        // R2 error flag
        panel_ok = 1'b0;
        rd(1, v); check("R2 err set", {16'd0, v}, 32'h8000);
        wr(1, 16'h8000);
        panel_ok = 1'b1;
        rd(1, v); check("R2 err write ignored", {16'd0, v}, 0);

        // R5 clamp and width
        wr(3, 16'd1023); rd(3, v); check("R5 clamp 1023", {16'd0, v}, 1000);
        wr(3, 16'd1000); rd(3, v); check("R5 keep 1000", {16'd0, v}, 1000);
        wr(3, 16'hFC05); rd(3, v); check("R5 upper bits", {16'd0, v}, 5);

        // R3 period sweep, observed on irq with R8 enable set
        wr(1, 16'h0040);
        for (int p = 1; p <= 6; p++) begin
            wr(3, 16'(p));
            rd(1, v);
            for (int k = 1; k <= 2 * p; k++) begin
                tick();
                check($sformatf("R3 p=%0d k=%0d", p, k), {31'd0, irq}, ((k % p) == 0) ? 1 : 0);
                rd(1, v);
                check($sformatf("R7 evt p=%0d k=%0d", p, k), {31'd0, v[7]}, ((k % p) == 0) ? 1 : 0);
            end
        end

        // R4 zero period
        wr(3, 16'd0);
        for (int k = 0; k < 20; k++) begin
            tick();
            check("R4 no event", {31'd0, irq}, 0);
        end

        // R6 / R11 delayed copy and ordering
        wr(3, 16'd3);
        wr(4, 16'h1234);
        wr(5, 16'hABCD);
        rd(4, v); check("R6 readback0", {16'd0, v}, 32'h1234);
        rd(5, v); check("R6 readback1", {16'd0, v}, 32'hABCD);
        tick(); check("R6 hold t1", lamps, 0);
        tick(); check("R6 hold t2", lamps, 0);
        tick(); check("R11 copy order", lamps, 32'hABCD1234);
        rd(1, v);

        // R9 test modes
        wr(1, 16'h0041); check("R9 mode1", lamps, 32'hFFFFFFFF);
        wr(1, 16'h0042); check("R9 mode2", lamps, 32'hFFFFFFFF);
        wr(1, 16'h0043); check("R9 mode3", lamps, 0);
        wr(1, 16'h0040); check("R9 mode0", lamps, 32'hABCD1234);

        // R10 no panel
        panel_ok = 1'b0;
        wr(3, 16'd2);
        wr(4, 16'h5555);
        tick(); check("R10 t1 irq", {31'd0, irq}, 0);
        tick(); check("R10 t2 irq", {31'd0, irq}, 1);
        check("R10 lamps", lamps, 32'hABCD5555);
        rd(1, v); check("R10 status", {16'd0, v}, 32'h80C0);
        panel_ok = 1'b1;

        // R7 set wins over same-cycle read
        wr(3, 16'd1);
        rd(1, v);
        @(negedge clk);
        bus_word = WW'(1); bus_rd = 1'b1; tick_1ms = 1'b1;
        #1 v = bus_rdata;
        check("R7 old value read", {31'd0, v[7]}, 0);
        @(negedge clk);
        bus_rd = 1'b0; tick_1ms = 1'b0;
        #1 check("R7 set wins", {31'd0, irq}, 1);

        // R12 writes to bit 7
        wr(1, 16'h0040); rd(1, v); check("R12 keep set", {31'd0, v[7]}, 1);
        wr(1, 16'h00C0); rd(1, v); check("R12 no set", {31'd0, v[7]}, 0);

        // R8 enable gating
        wr(1, 16'h0000);
        tick();
        check("R8 masked", {31'd0, irq}, 0);
        wr(1, 16'h0040);
        #1 check("R8 late enable", {31'd0, irq}, 1);
        rd(1, v);
        #1 check("R8 cleared", {31'd0, irq}, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule